// File: doc/BRIEF.md
# Multiplexed-Bus Latch Port Expander

This block lets a host with only a narrow 8-bit multiplexed address/data bus control a wide SDRAM-side interface. It uses an ALE strobe and active-low read and write strobes. The host first places a latch index on the bus and pulses ALE. The index goes into a select register, which names a latch inside this block. It is never an SDRAM address. Later write strobes store the bus byte into that latch. Later read strobes return the byte of a data latch. The upper address byte, chip select and wait handshake are not used, and every access completes without wait states.

There are three kinds of latch. Write-only latches fan out to SDRAM control and address lines. Bidirectional data latches can also be loaded from the SDRAM side and read back by the host. A command latch turns each host write into exactly one pulse, one clock wide, in the fast SDRAM clock domain. All three host strobes are synchronized into that clock, so the host may run at any speed slower than the SDRAM clock. The bus is split into input, output and output-enable signals, so the pad or the board decides where the tri-state driver goes.

Top module: `bus_latch_expander`

## Requirements
- R1: After synchronous reset all latch outputs are zero. The command pulse is low, the bus output enable is low, and the bus output byte is 0xFF.
- R2: The bus byte present while ALE is high is loaded into the select register when ALE falls. Index map:
  - Indices 0 to 2 are write-only latches. Index i drives `side_wo[8i+7:8i]`.
  - Indices 4 to 7 are data latches. Index 4+j drives `side_dq[8j+7:8j]`.
  - Index 8 is the command latch.
  - Every other index is unused.
- R3: A write strobe to a write-only index stores the bus byte into that latch when the strobe is released. No other latch changes.
- R4: A write strobe to a data-latch index stores the bus byte into that data latch when the strobe is released. No other latch changes.
- R5: While the read strobe is low and a data latch is selected, the block drives that latch's byte on the bus with the output enable high.
- R6: While the read strobe is low and any other index is selected, the output enable stays low and the bus output byte is 0xFF. The host therefore reads 0xFF.
- R7: A write strobe to an unused index changes no latch output and produces no command pulse.
- R8: A write strobe to the command index produces exactly one `sdram_cmd_pulse` one clock wide, with `sdram_cmd_code` equal to the written byte. This holds for any strobe of at least two SDRAM clocks.
- R9: A one-clock `side_dq_load` loads `side_dq_in` into all data latches, and the host can then read the new bytes back. A host write committing in the same cycle wins for its own byte.
- R10: The select register keeps its value across any number of read and write strobes until the next ALE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | SDRAM-side clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ad_in | input | 8 | Multiplexed address/data bus as seen from the pads |
| host_ad_out | output | 8 | Read data toward the bus, 0xFF when not driving |
| host_ad_oe | output | 1 | Bus output enable |
| host_ale | input | 1 | Address latch enable, active high, asynchronous |
| host_rd_n | input | 1 | Read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Write strobe, active low, asynchronous |
| side_dq_in | input | 32 | SDRAM-side data for the data latches |
| side_dq_load | input | 1 | Loads side_dq_in into all data latches |
| side_wo | output | 24 | Write-only latch outputs (control and address lines) |
| side_dq | output | 32 | Data latch outputs |
| sdram_cmd_pulse | output | 1 | One-clock command pulse |
| sdram_cmd_code | output | 8 | Command byte, valid with the pulse and held after it |

## Verification
A wrong select register shows at the ports on the next strobe. A write lands in the wrong byte lane of `side_wo` or `side_dq`, or a read returns another latch's byte or 0xFF where data was expected. Either appears about four clocks after the strobe is released.

A broken one-shot appears within one clock of the commit, as a pulse that is missing, doubled or two cycles wide. A faulty decode of unused indices shows as a changed output byte or a stray pulse on the very next observation.

// File: rtl/blx_pkg.sv
package blx_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_WO   = 2'd1,
    KIND_DQ   = 2'd2,
    KIND_CMD  = 2'd3
  } latch_kind_e;
endpackage

// File: rtl/blx_sync.sv
module blx_sync #(
  parameter int   STAGES  = 2,
  parameter logic IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE_LV}};
      prev  <= IDLE_LV;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/blx_host_if.sv
module blx_host_if #(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             ale,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [BUS_W-1:0] rd_byte,
  input  logic             rd_ok,
  output logic [BUS_W-1:0] sel,
  output logic [BUS_W-1:0] wdata,
  output logic             wr_commit,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe
);
  localparam int NSTROBE = 3;
  localparam int S_ALE = 0;
  localparam int S_RD  = 1;
  localparam int S_WR  = 2;

  logic [NSTROBE-1:0] strobe_raw;
  logic [NSTROBE-1:0] strobe_lvl;
  logic [NSTROBE-1:0] strobe_rise;
  logic [NSTROBE-1:0] strobe_fall;
  logic [BUS_W-1:0]   bus_q;
  logic [BUS_W-1:0]   idx_hold;

  assign strobe_raw = {wr_n, rd_n, ale};

  for (genvar g = 0; g < NSTROBE; g++) begin : g_sync
    blx_sync #(
      .STAGES (SYNC_STAGES),
      .IDLE_LV((g == S_ALE) ? 1'b0 : 1'b1)
    ) i_sync (
      .clk     (clk),
      .rst     (rst),
      .async_in(strobe_raw[g]),
      .level   (strobe_lvl[g]),
      .rise    (strobe_rise[g]),
      .fall    (strobe_fall[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q     <= '0;
      idx_hold  <= '0;
      sel       <= '0;
      wdata     <= '0;
      wr_commit <= 1'b0;
      bus_oe    <= 1'b0;
      bus_out   <= '1;
    end else begin
      bus_q <= bus_in;
      if (strobe_lvl[S_ALE]) idx_hold <= bus_q;
      if (strobe_fall[S_ALE]) sel <= idx_hold;
      if (!strobe_lvl[S_WR]) wdata <= bus_q;
      wr_commit <= strobe_rise[S_WR];
      bus_oe    <= !strobe_lvl[S_RD] && rd_ok;
      bus_out   <= (!strobe_lvl[S_RD] && rd_ok) ? rd_byte : '1;
    end
  end

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    !strobe_fall[S_ALE] |=> $stable(sel)) else $error("select changed without ALE"); // R10

  AST_COMMIT_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> $past(strobe_lvl[S_WR]) && !$past(strobe_lvl[S_WR], 2)) else $error("commit without strobe release"); // R3

  logic unused_rise;
  assign unused_rise = |{strobe_rise[S_ALE], strobe_rise[S_RD], strobe_fall[S_RD], strobe_fall[S_WR]};
endmodule

// File: rtl/blx_latch_bank.sv
module blx_latch_bank
  import blx_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int WO_BYTES  = 3,
  parameter int DQ_BYTES  = 4,
  parameter int DQ_BASE   = 4,
  parameter int CMD_INDEX = 8,
  localparam int WO_W     = WO_BYTES * BUS_W,
  localparam int DQ_W     = DQ_BYTES * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] sel,
  input  logic [BUS_W-1:0] wdata,
  input  logic             wr_commit,
  input  logic             cap_en,
  input  logic [DQ_W-1:0]  cap_data,
  output logic [WO_W-1:0]  wo_flat,
  output logic [DQ_W-1:0]  dq_flat,
  output logic             cmd_pulse,
  output logic [BUS_W-1:0] cmd_code,
  output logic [BUS_W-1:0] rd_byte,
  output logic             rd_ok
);
  latch_kind_e kind;
  int          sel_i;

  always_comb begin
    sel_i = int'(sel);
    if (sel_i < WO_BYTES)                                   kind = KIND_WO;
    else if (sel_i >= DQ_BASE && sel_i < DQ_BASE + DQ_BYTES) kind = KIND_DQ;
    else if (sel_i == CMD_INDEX)                            kind = KIND_CMD;
    else                                                    kind = KIND_NONE;
  end

  for (genvar i = 0; i < WO_BYTES; i++) begin : g_wo
    localparam logic [BUS_W-1:0] MY_IDX = BUS_W'(i);
    logic [BUS_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr_commit && kind == KIND_WO && sel == MY_IDX) q <= wdata;
    end
    assign wo_flat[i*BUS_W +: BUS_W] = q;
  end

  for (genvar j = 0; j < DQ_BYTES; j++) begin : g_dq
    localparam logic [BUS_W-1:0] MY_IDX = BUS_W'(DQ_BASE + j);
    logic [BUS_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr_commit && kind == KIND_DQ && sel == MY_IDX) q <= wdata;
      else if (cap_en) q <= cap_data[j*BUS_W +: BUS_W];
    end
    assign dq_flat[j*BUS_W +: BUS_W] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_pulse <= 1'b0;
      cmd_code  <= '0;
    end else begin
      cmd_pulse <= wr_commit && kind == KIND_CMD;
      if (wr_commit && kind == KIND_CMD) cmd_code <= wdata;
    end
  end

  always_comb begin
    rd_byte = '1;
    for (int j = 0; j < DQ_BYTES; j++) begin
      if (sel == BUS_W'(DQ_BASE + j)) rd_byte = dq_flat[j*BUS_W +: BUS_W];
    end
  end
  assign rd_ok = (kind == KIND_DQ);

  AST_ONE_CLOCK_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_pulse |=> !cmd_pulse) else $error("command pulse wider than one clock"); // R8

  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cmd_pulse |-> $past(wr_commit)) else $error("command pulse without commit"); // R8

  AST_UNUSED_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && kind == KIND_NONE && !cap_en) |=> ($stable(wo_flat) && $stable(dq_flat) && !cmd_pulse))
    else $error("unused index write had an effect"); // R7

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (cap_en && !wr_commit) |=> (dq_flat == $past(cap_data))) else $error("side load missed"); // R9
endmodule

// File: rtl/bus_latch_expander.sv
module bus_latch_expander #(
  parameter int BUS_W       = 8,
  parameter int WO_BYTES    = 3,
  parameter int DQ_BYTES    = 4,
  parameter int DQ_BASE     = 4,
  parameter int CMD_INDEX   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int WO_W       = WO_BYTES * BUS_W,
  localparam int DQ_W       = DQ_BYTES * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] host_ad_in,
  output logic [BUS_W-1:0] host_ad_out,
  output logic             host_ad_oe,
  input  logic             host_ale,
  input  logic             host_rd_n,
  input  logic             host_wr_n,
  input  logic [DQ_W-1:0]  side_dq_in,
  input  logic             side_dq_load,
  output logic [WO_W-1:0]  side_wo,
  output logic [DQ_W-1:0]  side_dq,
  output logic             sdram_cmd_pulse,
  output logic [BUS_W-1:0] sdram_cmd_code
);
  logic [BUS_W-1:0] sel;
  logic [BUS_W-1:0] wdata;
  logic             wr_commit;
  logic [BUS_W-1:0] rd_byte;
  logic             rd_ok;

  blx_host_if #(
    .BUS_W      (BUS_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_host_if (
    .clk      (clk),
    .rst      (rst),
    .bus_in   (host_ad_in),
    .ale      (host_ale),
    .rd_n     (host_rd_n),
    .wr_n     (host_wr_n),
    .rd_byte  (rd_byte),
    .rd_ok    (rd_ok),
    .sel      (sel),
    .wdata    (wdata),
    .wr_commit(wr_commit),
    .bus_out  (host_ad_out),
    .bus_oe   (host_ad_oe)
  );

  blx_latch_bank #(
    .BUS_W    (BUS_W),
    .WO_BYTES (WO_BYTES),
    .DQ_BYTES (DQ_BYTES),
    .DQ_BASE  (DQ_BASE),
    .CMD_INDEX(CMD_INDEX)
  ) i_latch_bank (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .wdata    (wdata),
    .wr_commit(wr_commit),
    .cap_en   (side_dq_load),
    .cap_data (side_dq_in),
    .wo_flat  (side_wo),
    .dq_flat  (side_dq),
    .cmd_pulse(sdram_cmd_pulse),
    .cmd_code (sdram_cmd_code),
    .rd_byte  (rd_byte),
    .rd_ok    (rd_ok)
  );

  AST_DRIVE_ONLY_BIDIR: assert property (@(posedge clk) disable iff (rst)
    host_ad_oe |-> $past(rd_ok)) else $error("bus driven for a non-data latch"); // R6

  AST_IDLE_BYTE: assert property (@(posedge clk) disable iff (rst)
    !host_ad_oe |-> (host_ad_out == '1)) else $error("idle bus byte not all ones"); // R6
endmodule

// File: tb/test_bus_latch_expander.sv
module test_bus_latch_expander;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  host_ad_in = 8'h00;
  logic [7:0]  host_ad_out;
  logic        host_ad_oe;
  logic        host_ale = 1'b0;
  logic        host_rd_n = 1'b1;
  logic        host_wr_n = 1'b1;
  logic [31:0] side_dq_in = '0;
  logic        side_dq_load = 1'b0;
  logic [23:0] side_wo;
  logic [31:0] side_dq;
  logic        sdram_cmd_pulse;
  logic [7:0]  sdram_cmd_code;

  int checks = 0;
  int errors = 0;
  int pulses_seen = 0;
  int wide_pulses = 0;
  logic prev_pulse = 1'b0;
  logic [7:0] last_code = 8'h00;
  bit done = 0;

  logic [7:0] m_wo [3];
  logic [7:0] m_dq [4];
  int         m_pulses = 0;
  logic [7:0] m_code = 8'h00;

  always #10 clk = ~clk;

  bus_latch_expander i_bus_latch_expander (
    .clk            (clk),
    .rst            (rst),
    .host_ad_in     (host_ad_in),
    .host_ad_out    (host_ad_out),
    .host_ad_oe     (host_ad_oe),
    .host_ale       (host_ale),
    .host_rd_n      (host_rd_n),
    .host_wr_n      (host_wr_n),
    .side_dq_in     (side_dq_in),
    .side_dq_load   (side_dq_load),
    .side_wo        (side_wo),
    .side_dq        (side_dq),
    .sdram_cmd_pulse(sdram_cmd_pulse),
    .sdram_cmd_code (sdram_cmd_code)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (sdram_cmd_pulse) begin
        pulses_seen++;
        last_code = sdram_cmd_code;
        if (prev_pulse) wide_pulses++;
      end
      prev_pulse = sdram_cmd_pulse;
    end
  end

  function automatic int kind_of(input logic [7:0] idx);
    if (idx < 3) return 1;
    if (idx >= 4 && idx <= 7) return 2;
    if (idx == 8) return 3;
    return 0;
  endfunction

  function automatic logic [23:0] exp_wo();
    return {m_wo[2], m_wo[1], m_wo[0]};
  endfunction

  function automatic logic [31:0] exp_dq();
    return {m_dq[3], m_dq[2], m_dq[1], m_dq[0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ale_cycle(input logic [7:0] idx);
    @(negedge clk);
    host_ad_in = idx;
    host_ale = 1'b1;
    repeat (4) @(negedge clk);
    host_ale = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_cycle(input logic [7:0] idx, input logic [7:0] d, input int len);
    @(negedge clk);
    host_ad_in = d;
    @(negedge clk);
    host_wr_n = 1'b0;
    repeat (len) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (6) @(negedge clk);
    case (kind_of(idx))
      1: m_wo[idx] = d;
      2: m_dq[idx - 4] = d;
      3: begin m_pulses++; m_code = d; end
      default: ;
    endcase
  endtask

  task automatic rd_check(input logic [7:0] idx, input string req);
    logic [7:0] exp;
    exp = (kind_of(idx) == 2) ? m_dq[idx - 4] : 8'hFF;
    @(negedge clk);
    host_ad_in = 8'h5A;
    host_rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(req, {56'd0, (host_ad_oe ? host_ad_out : 8'hFF)}, {56'd0, exp});
    chk(req, {63'd0, host_ad_oe}, {63'd0, kind_of(idx) == 2});
    host_rd_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(req, {63'd0, host_ad_oe}, 64'd0);
  endtask

  task automatic state_check(input string req);
    chk(req, {40'd0, side_wo}, {40'd0, exp_wo()});
    chk(req, {32'd0, side_dq}, {32'd0, exp_dq()});
    chk(req, 64'(pulses_seen), 64'(m_pulses));
  endtask

  task automatic side_load(input logic [31:0] v);
    @(negedge clk);
    side_dq_in = v;
    side_dq_load = 1'b1;
    @(negedge clk);
    side_dq_load = 1'b0;
    for (int j = 0; j < 4; j++) m_dq[j] = v[j*8 +: 8];
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20160904));
    for (int i = 0; i < 3; i++) m_wo[i] = 8'h00;
    for (int j = 0; j < 4; j++) m_dq[j] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 wo", {40'd0, side_wo}, 64'd0);
    chk("R1 dq", {32'd0, side_dq}, 64'd0);
    chk("R1 pulse", {63'd0, sdram_cmd_pulse}, 64'd0);
    chk("R1 oe", {63'd0, host_ad_oe}, 64'd0);
    chk("R1 bus", {56'd0, host_ad_out}, 64'hFF);

    // R2 R3 write-only lanes
    for (int i = 0; i < 3; i++) begin
      ale_cycle(8'(i));
      wr_cycle(8'(i), 8'hA0 + 8'(i), 3);
      state_check("R3");
    end
    // R2 R4 data lanes and R5 readback
    for (int j = 4; j < 8; j++) begin
      ale_cycle(8'(j));
      wr_cycle(8'(j), 8'h30 + 8'(j * 7), 2);
      state_check("R4");
      rd_check(8'(j), "R5");
    end
    // R6 read of non-data latches
    ale_cycle(8'd1);  rd_check(8'd1, "R6");
    ale_cycle(8'd8);  rd_check(8'd8, "R6");
    ale_cycle(8'd77); rd_check(8'd77, "R6");
    // R7 unused indices
    ale_cycle(8'd3);   wr_cycle(8'd3, 8'hEE, 3);   state_check("R7");
    ale_cycle(8'd255); wr_cycle(8'd255, 8'h11, 3); state_check("R7");
    // R8 command pulse for short and long strobes
    ale_cycle(8'd8);
    wr_cycle(8'd8, 8'h91, 2);
    state_check("R8");
    chk("R8 code", {56'd0, last_code}, {56'd0, m_code});
    wr_cycle(8'd8, 8'h42, 40);
    state_check("R8");
    chk("R8 code", {56'd0, last_code}, {56'd0, m_code});
    chk("R8 width", 64'(wide_pulses), 64'd0);
    // R10 select kept across strobes
    ale_cycle(8'd6);
    wr_cycle(8'd6, 8'hC3, 3);
    rd_check(8'd6, "R10");
    wr_cycle(8'd6, 8'h3C, 5);
    rd_check(8'd6, "R10");
    state_check("R10");
    // R9 side load then readback
    side_load(32'hDEADBEEF);
    state_check("R9");
    ale_cycle(8'd5); rd_check(8'd5, "R9");

    // random mix
    for (int n = 0; n < 150; n++) begin
      logic [7:0] idx;
      int op;
      int r;
      r = int'($urandom % 16);
      idx = (r < 12) ? 8'(r) : 8'($urandom % 256);
      op = int'($urandom % 4);
      if (op == 3) begin
        side_load($urandom);
        state_check("R9");
      end else begin
        ale_cycle(idx);
        if (op == 2) begin
          rd_check(idx, (kind_of(idx) == 2) ? "R5" : "R6");
        end else begin
          wr_cycle(idx, 8'($urandom), 2 + int'($urandom % 10));
          case (kind_of(idx))
            1: state_check("R3");
            2: state_check("R4");
            3: begin
              state_check("R8");
              chk("R8 code", {56'd0, last_code}, {56'd0, m_code});
            end
            default: state_check("R7");
          endcase
        end
      end
    end
    chk("R8 width", 64'(wide_pulses), 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule